// File: doc/BRIEF.md
# Synchronous Memory-Card Line Decoder

This block observes the reset, clock and data lines of a synchronous memory-card interface. A two-flop synchroniser first brings the lines into the system clock domain. The block then turns the line activity into one-cycle event pulses:

- reset and interrupt, at the end of a reset pulse;
- start and stop, from data-line edges while the card clock is high;
- received bits;
- assembled bytes.

It also forwards every card-clock falling edge that falls outside reset, so a downstream phase tracker can count clocks. That tracker decides what the bytes mean. It drives one input back, which blocks start and stop recognition during phases where the data line moves freely.

Edges are found by comparing the synchronised sample with the one from the previous cycle. When the card clock and the data line change in the same system cycle, the data line is treated as having changed first, while the clock still held its old level. Every event output is registered.

Top module: `mcard_line_decoder`

## Requirements
- R1: After the system reset, every event output and byte_o are low.
- R2: A reset pulse on line_rst_i that contains at least one card-clock rising edge produces exactly one reset_evt_o pulse and no intr_evt_o, after the line falls.
- R3: A reset pulse with no card-clock rising edge inside it produces exactly one intr_evt_o pulse and no reset_evt_o.
- R4: While line_rst_i is high, clock and data activity produces no bit, byte, start, stop or clk_fall_o pulse.
- R5: With reset low and the card clock high, a falling data line produces start_evt_o and a rising data line produces stop_evt_o.
- R6: While phase_quiet_i is high, data-line edges under a high card clock produce neither start_evt_o nor stop_evt_o.
- R7: The bit value is the data line level at a card-clock rising edge. bit_valid_o pulses with that value at the following falling edge.
- R8: Eight completed bits give one byte_valid_o pulse, and byte_o carries the first bit in bit 0 and the eighth in bit 7.
- R9: A start, a stop, a reset event or an interrupt event discards any partly assembled byte.
- R10: Every card-clock falling edge while reset is low gives one clk_fall_o pulse.
- R11: If the data line and the card clock change in the same system cycle, the data line is judged against the previous clock level. A start then takes priority, and the bit pending on that clock pulse is dropped.
- R12: Every event output is high for one system cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| line_rst_i | input | 1 | Card reset line, asynchronous |
| line_clk_i | input | 1 | Card clock line, asynchronous |
| line_io_i | input | 1 | Card data line, asynchronous |
| phase_quiet_i | input | 1 | High blocks start/stop recognition |
| bit_valid_o | output | 1 | Bit completed pulse |
| bit_o | output | 1 | Value of the completed bit |
| byte_valid_o | output | 1 | Byte completed pulse |
| byte_o | output | 8 | Assembled byte, first bit in bit 0 |
| reset_evt_o | output | 1 | Reset pulse with clock seen |
| intr_evt_o | output | 1 | Reset pulse without clock |
| start_evt_o | output | 1 | Start condition |
| stop_evt_o | output | 1 | Stop condition |
| clk_fall_o | output | 1 | Card-clock falling edge outside reset |

## Verification
Two functions can land in the same system cycle: a start/stop recognition and the completion of a bit. This happens when the data line and the card clock change together. The bench provokes it by moving both lines on the same system-clock edge. It does this once with the clock falling, and once with the clock rising and the data line changing.

It then judges the result at the ports. In the first case, a start must appear and no bit may complete. In the second case, there must be no stop, and the bit must carry the new data level.

// File: rtl/mcard_line_decoder.sv
module mcard_line_decoder #(
  parameter int SYNC   = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_rst_i,
  input  logic              line_clk_i,
  input  logic              line_io_i,
  input  logic              phase_quiet_i,
  output logic              bit_valid_o,
  output logic              bit_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              reset_evt_o,
  output logic              intr_evt_o,
  output logic              start_evt_o,
  output logic              stop_evt_o,
  output logic              clk_fall_o
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [3*SYNC-1:0] chain;
  logic [2:0]        cur, prv;
  logic              seen, pend, bval;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] shreg;

  assign cur = chain[3*SYNC-1 -: 3];

  wire rst_lo   = !cur[2] && !prv[2];
  wire rst_fall = prv[2] && !cur[2];
  wire c_rise   = cur[1] && !prv[1];
  wire c_fall   = !cur[1] && prv[1];
  wire d_rise   = cur[0] && !prv[0];
  wire d_fall   = !cur[0] && prv[0];
  wire cond_ok  = rst_lo && prv[1] && !phase_quiet_i;
  wire st_w     = cond_ok && d_fall;
  wire sp_w     = cond_ok && d_rise;
  wire done_w   = rst_lo && c_fall && pend && !st_w && !sp_w;
  wire [BYTE_W-1:0] next_sh = {bval, shreg[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      prv   <= '0;
    end else begin
      chain <= {chain[3*SYNC-4:0], line_rst_i, line_clk_i, line_io_i};
      prv   <= cur;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0; pend <= 1'b0; bval <= 1'b0;
      cnt <= '0; shreg <= '0; byte_o <= '0; bit_o <= 1'b0;
      bit_valid_o <= 1'b0; byte_valid_o <= 1'b0;
      reset_evt_o <= 1'b0; intr_evt_o <= 1'b0;
      start_evt_o <= 1'b0; stop_evt_o <= 1'b0; clk_fall_o <= 1'b0;
    end else begin
      bit_valid_o  <= 1'b0;
      byte_valid_o <= 1'b0;
      reset_evt_o  <= 1'b0;
      intr_evt_o   <= 1'b0;
      start_evt_o  <= 1'b0;
      stop_evt_o   <= 1'b0;
      clk_fall_o   <= 1'b0;
      if (cur[2]) begin
        pend <= 1'b0;
        if (!prv[2]) seen <= 1'b0;
        if (c_rise)  seen <= 1'b1;
      end else if (rst_fall) begin
        reset_evt_o <= seen;
        intr_evt_o  <= !seen;
        seen <= 1'b0;
        pend <= 1'b0;
        cnt  <= '0;
      end else begin
        clk_fall_o  <= c_fall;
        start_evt_o <= st_w;
        stop_evt_o  <= sp_w;
        if (st_w || sp_w) begin
          cnt  <= '0;
          pend <= 1'b0;
        end else begin
          if (c_rise) begin
            pend <= 1'b1;
            bval <= cur[0];
          end
          if (done_w) begin
            pend        <= 1'b0;
            bit_valid_o <= 1'b1;
            bit_o       <= bval;
            shreg       <= next_sh;
            if (cnt == LAST) begin
              cnt          <= '0;
              byte_valid_o <= 1'b1;
              byte_o       <= next_sh;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/mcard_line_decoder_chk.sv
module mcard_line_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic phase_quiet_i,
  input logic bit_valid_o,
  input logic byte_valid_o,
  input logic reset_evt_o,
  input logic intr_evt_o,
  input logic start_evt_o,
  input logic stop_evt_o
);
  AST_RST_INTR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reset_evt_o && intr_evt_o)); // R2
  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt_o && stop_evt_o)); // R5
  AST_QUIET_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(phase_quiet_i) |-> !(start_evt_o || stop_evt_o)); // R6
  AST_BYTE_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> bit_valid_o); // R8
  AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt_o || stop_evt_o) |-> !bit_valid_o); // R11
  AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_evt_o |=> !reset_evt_o); // R12
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt_o |=> !start_evt_o); // R12
endmodule

bind mcard_line_decoder mcard_line_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase_quiet_i(phase_quiet_i),
  .bit_valid_o(bit_valid_o), .byte_valid_o(byte_valid_o),
  .reset_evt_o(reset_evt_o), .intr_evt_o(intr_evt_o),
  .start_evt_o(start_evt_o), .stop_evt_o(stop_evt_o)
);

// File: tb/test_mcard_line_decoder.sv
module test_mcard_line_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic l_rst = 1'b0, l_clk = 1'b0, l_io = 1'b1, quiet = 1'b0;
  logic bit_valid, bit_v, byte_valid, reset_evt, intr_evt, start_evt, stop_evt, clk_fall;
  logic [7:0] byte_v;
  int n_chk = 0, n_bad = 0;
  int c_bit = 0, c_byte = 0, c_rst = 0, c_int = 0, c_st = 0, c_sp = 0, c_fall = 0;
  logic [7:0] last_byte = '0;
  logic last_bit = 1'b0;
  bit wd = 1'b0;

  always #2.5 clk = ~clk;

  mcard_line_decoder i_mcard_line_decoder (
    .clk(clk), .rst_n(rst_n), .line_rst_i(l_rst), .line_clk_i(l_clk),
    .line_io_i(l_io), .phase_quiet_i(quiet), .bit_valid_o(bit_valid),
    .bit_o(bit_v), .byte_valid_o(byte_valid), .byte_o(byte_v),
    .reset_evt_o(reset_evt), .intr_evt_o(intr_evt), .start_evt_o(start_evt),
    .stop_evt_o(stop_evt), .clk_fall_o(clk_fall));

  always @(negedge clk) if (rst_n) begin
    if (bit_valid) begin c_bit++; last_bit = bit_v; end
    if (byte_valid) begin c_byte++; last_byte = byte_v; end
    if (reset_evt) c_rst++;
    if (intr_evt) c_int++;
    if (start_evt) c_st++;
    if (stop_evt) c_sp++;
    if (clk_fall) c_fall++;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    l_io = b; hold(4);
    l_clk = 1'b1; hold(4);
    l_clk = 1'b0; hold(4);
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic do_start();
    l_io = 1'b1; hold(4);
    l_clk = 1'b1; hold(4);
    l_io = 1'b0; hold(4);
    l_clk = 1'b0; hold(4);
  endtask

  task automatic do_stop();
    l_io = 1'b0; hold(4);
    l_clk = 1'b1; hold(4);
    l_io = 1'b1; hold(4);
    l_clk = 1'b0; hold(4);
  endtask

  task automatic t_reset_state();
    check("R1 bit_valid", bit_valid, 0);
    check("R1 byte_valid", byte_valid, 0);
    check("R1 events", int'({reset_evt, intr_evt, start_evt, stop_evt, clk_fall}), 0);
    check("R1 byte", byte_v, 0);
  endtask

  task automatic t_reset_with_clk();
    int r0 = c_rst, i0 = c_int, b0 = c_bit, f0 = c_fall, s0 = c_st + c_sp;
    l_rst = 1'b1; hold(4);
    l_clk = 1'b1; hold(4);
    l_io = 1'b0; hold(4);
    l_io = 1'b1; hold(4);
    l_clk = 1'b0; hold(4);
    l_rst = 1'b0; hold(8);
    check("R2 reset count (R12 single cycle)", c_rst - r0, 1);
    check("R2 no intr", c_int - i0, 0);
    check("R4 no bits in reset", c_bit - b0, 0);
    check("R4 no clk_fall in reset", c_fall - f0, 0);
    check("R4 no start/stop in reset", c_st + c_sp - s0, 0);
  endtask

  task automatic t_intr();
    int r0 = c_rst, i0 = c_int;
    l_rst = 1'b1; hold(4);
    l_io = 1'b0; hold(4);
    l_io = 1'b1; hold(4);
    l_rst = 1'b0; hold(8);
    check("R3 intr count", c_int - i0, 1);
    check("R3 no reset", c_rst - r0, 0);
  endtask

  task automatic t_start_stop();
    int s0 = c_st, p0 = c_sp;
    do_start(); hold(4);
    check("R5 start", c_st - s0, 1);
    check("R5 no stop on start", c_sp - p0, 0);
    do_stop(); hold(4);
    check("R5 stop", c_sp - p0, 1);
  endtask

  task automatic t_byte();
    int b0, y0, f0;
    do_start();
    b0 = c_bit; y0 = c_byte; f0 = c_fall;
    send_bit(1'b1); hold(2);
    check("R7 bit count", c_bit - b0, 1);
    check("R7 bit value", last_bit, 1);
    send_bit(1'b0); hold(2);
    check("R7 bit value zero", last_bit, 0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); hold(4);
    check("R8 byte count", c_byte - y0, 1);
    check("R8 byte LSB first", last_byte, 8'hA5);
    check("R10 clk_fall per bit", c_fall - f0, 8);
  endtask

  task automatic t_clear();
    int y0;
    do_start();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    do_start();
    y0 = c_byte;
    send_byte(8'h3C); hold(4);
    check("R9 start clears count", c_byte - y0, 1);
    check("R9 start clears value", last_byte, 8'h3C);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    l_rst = 1'b1; hold(4); l_rst = 1'b0; hold(8);
    y0 = c_byte;
    send_byte(8'h81); hold(4);
    check("R9 intr clears count", c_byte - y0, 1);
    check("R9 intr clears value", last_byte, 8'h81);
  endtask

  task automatic t_quiet();
    int s0 = c_st, p0 = c_sp;
    quiet = 1'b1;
    l_io = 1'b1; hold(4);
    l_clk = 1'b1; hold(4);
    l_io = 1'b0; hold(4);
    l_io = 1'b1; hold(4);
    l_clk = 1'b0; hold(6);
    quiet = 1'b0; hold(2);
    check("R6 start blocked", c_st - s0, 0);
    check("R6 stop blocked", c_sp - p0, 0);
  endtask

  task automatic t_same();
    int s0, p0, b0;
    l_io = 1'b1; hold(4);
    l_clk = 1'b1; hold(4);
    s0 = c_st; b0 = c_bit;
    l_io = 1'b0; l_clk = 1'b0; hold(6);
    check("R11 start on joint change", c_st - s0, 1);
    check("R11 pending bit dropped", c_bit - b0, 0);
    p0 = c_sp; b0 = c_bit;
    l_io = 1'b1; l_clk = 1'b1; hold(4);
    l_clk = 1'b0; hold(6);
    check("R11 no stop on joint rise", c_sp - p0, 0);
    check("R11 bit completes", c_bit - b0, 1);
    check("R11 bit takes new level", last_bit, 1);
  endtask

  initial begin
    fork
      begin
        hold(3);
        rst_n = 1'b1;
        hold(1);
        t_reset_state();
        hold(8);
        t_reset_with_clk();
        t_intr();
        t_start_stop();
        t_byte();
        t_clear();
        t_quiet();
        t_same();
      end
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    if (wd) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule